// File: doc/BRIEF.md
# Masked Raster-Op Pixel Write Unit

This block sits between an 8-bit host port and a bit-mapped display store. For every host write it fetches the eight pixels that the host byte covers, combines them with the host byte under one of five logic operations, and writes the result back. A mask restricts which of the eight pixels may change. Host reads go through the same pixel fetch, and the returned byte is masked before it reaches the host. A stored 1 is a lit pixel and a 0 is a dark pixel.

The store is treated as a plane of single pixels. The block works out a pixel coordinate for each of its eight bit lanes from a base coordinate and an orientation select. In vertical orientation the byte runs down one column with its MSB on the top pixel. In horizontal orientation it runs along one row with its MSB on the leftmost pixel. The store returns read data one cycle after a fetch and honours a separate write enable for each lane. Moving the base coordinate between accesses is left to the surrounding logic.

Top module: `rop_write_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`, `rd_valid` and `mem_rd` are 0 and `mem_we` is all zeros. The mask register resets to 8'hFF.
- R2: An accepted write asserts `busy` for exactly two cycles. In the first cycle `mem_rd` is 1. In the second cycle `mem_rd` is 0 and the write enables are driven. The store is updated at the clock edge that ends the second cycle.
- R3: Lane i (bit i of the byte) uses offset 7-i. With `horiz`=0 its pixel is (x, y+7-i). With `horiz`=1 its pixel is (x+7-i, y). Sums wrap modulo 2^XW or 2^YW. The lane coordinates stay stable through the whole transaction.
- R4: The operation codes on `req_op` are 0 replace (new=d), 1 AND (old&d), 2 OR (old|d), 3 XOR (old^d) and 4 invert (new=~old, host data ignored).
- R5: A pixel whose mask bit is 0 keeps its stored value. For codes 0 to 4, `mem_we` in the write-back cycle equals the mask.
- R6: Codes 5, 6 and 7 run the same two-cycle sequence but drive `mem_we` to zero, so the store does not change.
- R7: An accepted read gives `mem_rd`=1 in its first cycle. In its second cycle `rd_valid` is 1 for one cycle, and `rd_data` is the stored byte ANDed with the mask, so masked-off bits read as 0.
- R8: Requests made while `busy` is 1 are ignored. When `req_wr` and `req_rd` are both 1 in an idle cycle, only the write is performed and `rd_valid` stays 0.
- R9: `mask_we` loads `mask_in` at any clock edge. A transaction uses the mask value held at the edge that accepts it, so a mask load during a transaction applies only from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_we | input | 1 | Load the mask register |
| mask_in | input | DW | New mask value |
| req_wr | input | 1 | Request a raster-op write |
| req_rd | input | 1 | Request a masked read |
| req_op | input | 3 | Operation code (see R4, R6) |
| req_horiz | input | 1 | 0 = byte down a column, 1 = byte along a row |
| req_x | input | XW | Base pixel column |
| req_y | input | YW | Base pixel row |
| req_data | input | DW | Host byte |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_data | output | DW | Masked read data |
| mem_rd | output | 1 | Fetch the eight lane pixels |
| mem_we | output | DW | Write enable for each lane |
| mem_x | output | DW*XW | Column of each lane, lane i at [i*XW +: XW] |
| mem_y | output | DW*YW | Row of each lane, lane i at [i*YW +: YW] |
| mem_wdata | output | DW | Write-back pixel values |
| mem_rdata | input | DW | Fetched pixel values, valid one cycle after `mem_rd` |

## Verification
Request inputs are sampled at a rising edge, the accepting edge. The fetch strobe and the lane coordinates are due in the cycle after that edge. The write enables are due in the following cycle, and the updated store can be seen after the third edge. For a read, `rd_valid` and `rd_data` are due in the second cycle after the accepting edge. The bench drives inputs and samples outputs on falling edges and counts edges from the accepting one, so each check lands in the cycle where its result is due. After every write the bench compares the whole store against a pixel-array model that it keeps on its own.

// File: rtl/rop_pkg.sv
// Package: shared encodings for the raster-op write unit.
// Assumes operation codes are 3 bits wide. Codes above 4 are reserved.
package rop_pkg;

    typedef enum logic [2:0] {
        ROP_SET = 3'd0,
        ROP_AND = 3'd1,
        ROP_OR  = 3'd2,
        ROP_XOR = 3'd3,
        ROP_INV = 3'd4
    } rop_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR_FETCH,
        SQ_WR_COMMIT,
        SQ_RD_FETCH,
        SQ_RD_RETURN
    } sq_state_e;

    // True for the codes that are allowed to change pixels.
    function automatic logic rop_op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    // One-pixel combine of a stored bit with a host bit.
    function automatic logic rop_bit(input logic [2:0] code, input logic old_b, input logic host_b);
        logic res;
        case (code)
            ROP_SET: res = host_b;
            ROP_AND: res = old_b & host_b;
            ROP_OR:  res = old_b | host_b;
            ROP_XOR: res = old_b ^ host_b;
            ROP_INV: res = ~old_b;
            default: res = old_b;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rop_sequencer.sv
// Module: rop_sequencer
// Runs the transaction state machine. A write goes through fetch and then
// commit. A read goes through fetch and then return. Requests are taken
// only when idle, and a write wins over a read made in the same cycle.
// Assumes the store returns read data one cycle after the fetch strobe.
module rop_sequencer
    import rop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_rd,
    output logic accept,
    output logic busy,
    output logic fetch,
    output logic commit,
    output logic ret
);

    sq_state_e state_q, state_d;

    // Accept a request only in the idle state.
    always_comb begin
        accept = (state_q == SQ_IDLE) && (req_wr || req_rd);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE: begin
                if (req_wr)      state_d = SQ_WR_FETCH;
                else if (req_rd) state_d = SQ_RD_FETCH;
            end
            SQ_WR_FETCH:  state_d = SQ_WR_COMMIT;
            SQ_WR_COMMIT: state_d = SQ_IDLE;
            SQ_RD_FETCH:  state_d = SQ_RD_RETURN;
            SQ_RD_RETURN: state_d = SQ_IDLE;
            default:      state_d = SQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Phase strobes decoded from the state.
    always_comb begin
        busy   = (state_q != SQ_IDLE);
        fetch  = (state_q == SQ_WR_FETCH) || (state_q == SQ_RD_FETCH);
        commit = (state_q == SQ_WR_COMMIT);
        ret    = (state_q == SQ_RD_RETURN);
    end

endmodule

// File: rtl/rop_lane_map.sv
// Module: rop_lane_map
// Turns a base pixel coordinate and an orientation into one coordinate per
// bit lane. Lane i is offset by DW-1-i pixels, so the MSB sits on the top
// pixel (vertical) or the leftmost pixel (horizontal). Sums wrap.
module rop_lane_map #(
    parameter int DW = 8,
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic [XW-1:0]    base_x,
    input  logic [YW-1:0]    base_y,
    input  logic             horiz,
    output logic [DW*XW-1:0] lane_x,
    output logic [DW*YW-1:0] lane_y
);

    for (genvar g = 0; g < DW; g++) begin : g_lane
        localparam int OFF = DW - 1 - g;
        localparam logic [XW-1:0] OFF_X = XW'(OFF);
        localparam logic [YW-1:0] OFF_Y = YW'(OFF);

        // Step along the row or down the column by this lane's offset.
        always_comb begin
            lane_x[g*XW +: XW] = horiz ? (base_x + OFF_X) : base_x;
            lane_y[g*YW +: YW] = horiz ? base_y : (base_y + OFF_Y);
        end
    end

endmodule

// File: rtl/rop_alu.sv
// Module: rop_alu
// Combines the fetched pixels with the host byte, one lane at a time.
// A masked-off lane keeps its old value. Reserved codes enable no lane.
module rop_alu
    import rop_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] old_px,
    input  logic [DW-1:0] host,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] new_px,
    output logic [DW-1:0] lane_en
);

    logic known;

    // Decide once whether this code may change pixels.
    always_comb begin
        known = rop_op_known(op);
    end

    for (genvar g = 0; g < DW; g++) begin : g_bit
        // Per-lane combine, masked merge and enable.
        always_comb begin
            new_px[g]  = mask[g] ? rop_bit(op, old_px[g], host[g]) : old_px[g];
            lane_en[g] = mask[g] & known;
        end
    end

endmodule

// File: rtl/rop_write_unit.sv
// Module: rop_write_unit (top)
// Masked raster-op path between an 8-bit host port and a pixel store with
// per-lane addresses and write enables. A write is fetch then write-back.
// A read is fetch then masked return. Request fields and the mask are
// captured at the accepting edge. Assumes one-cycle read latency.
module rop_write_unit
    import rop_pkg::*;
#(
    parameter int DW = 8,
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [DW-1:0]    mask_in,
    input  logic             req_wr,
    input  logic             req_rd,
    input  logic [2:0]       req_op,
    input  logic             req_horiz,
    input  logic [XW-1:0]    req_x,
    input  logic [YW-1:0]    req_y,
    input  logic [DW-1:0]    req_data,
    output logic             busy,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             mem_rd,
    output logic [DW-1:0]    mem_we,
    output logic [DW*XW-1:0] mem_x,
    output logic [DW*YW-1:0] mem_y,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);

    logic          accept, fetch, commit, ret;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] mask_snap;
    logic [2:0]    op_q;
    logic          horiz_q;
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] alu_px, alu_en;

    // Mask register: all lanes open after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_in;
    end

    // Capture the request fields and the current mask on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_snap <= '1;
            op_q      <= '0;
            horiz_q   <= 1'b0;
            x_q       <= '0;
            y_q       <= '0;
            data_q    <= '0;
        end else if (accept) begin
            mask_snap <= mask_q;
            op_q      <= req_op;
            horiz_q   <= req_horiz;
            x_q       <= req_x;
            y_q       <= req_y;
            data_q    <= req_data;
        end
    end

    rop_sequencer i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_wr (req_wr),
        .req_rd (req_rd),
        .accept (accept),
        .busy   (busy),
        .fetch  (fetch),
        .commit (commit),
        .ret    (ret)
    );

    rop_lane_map #(.DW(DW), .XW(XW), .YW(YW)) i_map (
        .base_x (x_q),
        .base_y (y_q),
        .horiz  (horiz_q),
        .lane_x (mem_x),
        .lane_y (mem_y)
    );

    rop_alu #(.DW(DW)) i_alu (
        .op      (op_q),
        .old_px  (mem_rdata),
        .host    (data_q),
        .mask    (mask_snap),
        .new_px  (alu_px),
        .lane_en (alu_en)
    );

    // Drive the store and host outputs for the current phase.
    always_comb begin
        mem_rd    = fetch;
        mem_we    = commit ? alu_en : '0;
        mem_wdata = commit ? alu_px : '0;
        rd_valid  = ret;
        rd_data   = ret ? (mem_rdata & mask_snap) : '0;
    end

endmodule

// File: rtl/rop_write_unit_checker.sv
// Module: rop_write_unit_checker
// Checks the cycle ordering and masking rules at the ports of
// rop_write_unit. It is attached to the top by the bind at the end of this file.
module rop_write_unit_checker #(
    parameter int DW = 8,
    parameter int XW = 8,
    parameter int YW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_valid,
    input logic [DW-1:0]    rd_data,
    input logic             mem_rd,
    input logic [DW-1:0]    mem_we,
    input logic [DW*XW-1:0] mem_x,
    input logic [DW*YW-1:0] mem_y,
    input logic [DW-1:0]    mask_snap
);

    // R1: outputs are quiet in the cycle after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rd_valid && !mem_rd && mem_we == '0));

    // R2: a write-back is always preceded by a fetch.
    assert_fetch_before_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> $past(mem_rd));

    // R2: write enables appear only while busy.
    assert_we_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> busy);

    // R3: lane coordinates hold from fetch through write-back.
    assert_lanes_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> ($stable(mem_x) && $stable(mem_y)));

    // R7: read data follows a fetch, inside the transaction.
    assert_rdata_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(mem_rd) && busy));

    // R7: masked-off bits always read as zero.
    assert_read_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~mask_snap) == '0));

    // R8: one fetch per transaction, never two in a row.
    assert_single_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R8: a read return never overlaps a write-back.
    assert_no_mixed_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && (mem_we != '0)));

endmodule

bind rop_write_unit rop_write_unit_checker #(.DW(DW), .XW(XW), .YW(YW)) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .mem_x     (mem_x),
    .mem_y     (mem_y),
    .mask_snap (mask_snap)
);

// File: tb/test_rop_write_unit.sv
// Bench for rop_write_unit with a 16x16 pixel store and a separate
// reference pixel array.
module test_rop_write_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int XW = 4;
    localparam int YW = 4;
    localparam int NV = 12;

    // {op[2:0], horiz, x[3:0], y[3:0], data[7:0], mask[7:0]}
    localparam logic [27:0] VEC [0:NV-1] = '{
        {3'd0, 1'b0, 4'd2,  4'd3,  8'hA5, 8'hFF},
        {3'd0, 1'b1, 4'd4,  4'd9,  8'h3C, 8'hFF},
        {3'd1, 1'b0, 4'd2,  4'd3,  8'hF0, 8'hFF},
        {3'd2, 1'b1, 4'd4,  4'd9,  8'h81, 8'h0F},
        {3'd3, 1'b0, 4'd12, 4'd10, 8'hFF, 8'hF0},
        {3'd4, 1'b1, 4'd13, 4'd0,  8'h00, 8'hFF},
        {3'd4, 1'b1, 4'd13, 4'd0,  8'hFF, 8'h3C},
        {3'd0, 1'b0, 4'd7,  4'd7,  8'h00, 8'h00},
        {3'd5, 1'b0, 4'd2,  4'd3,  8'hFF, 8'hFF},
        {3'd7, 1'b1, 4'd4,  4'd9,  8'h00, 8'hFF},
        {3'd3, 1'b1, 4'd0,  4'd15, 8'h5A, 8'hA5},
        {3'd1, 1'b0, 4'd15, 4'd15, 8'h00, 8'h81}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_we = 1'b0;
    logic [DW-1:0] mask_in = '0;
    logic req_wr = 1'b0;
    logic req_rd = 1'b0;
    logic [2:0] req_op = '0;
    logic req_horiz = 1'b0;
    logic [XW-1:0] req_x = '0;
    logic [YW-1:0] req_y = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, rd_valid, mem_rd;
    logic [DW-1:0] rd_data, mem_we, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW*XW-1:0] mem_x;
    logic [DW*YW-1:0] mem_y;

    logic [15:0] pix  [16];
    logic [15:0] refm [16];
    logic [DW-1:0] cur_mask = 8'hFF;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rop_write_unit #(.DW(DW), .XW(XW), .YW(YW)) i_rop_write_unit (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_in(mask_in),
        .req_wr(req_wr), .req_rd(req_rd), .req_op(req_op), .req_horiz(req_horiz),
        .req_x(req_x), .req_y(req_y), .req_data(req_data),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_x(mem_x), .mem_y(mem_y),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic init_bit(input int x, input int y);
        return ((x * 3 + y * 5) % 7) < 3;
    endfunction

    // Pixel store: loaded with a pattern during reset, one-cycle read, per-lane write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int y = 0; y < 16; y++)
                for (int x = 0; x < 16; x++)
                    pix[y][x] <= init_bit(x, y);
        end else begin
            if (mem_rd)
                for (int i = 0; i < DW; i++)
                    mem_rdata[i] <= pix[mem_y[i*YW +: YW]][mem_x[i*XW +: XW]];
            for (int i = 0; i < DW; i++)
                if (mem_we[i]) pix[mem_y[i*YW +: YW]][mem_x[i*XW +: XW]] <= mem_wdata[i];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic ref_bit(input logic [2:0] op, input logic o, input logic d);
        case (op)
            3'd0: return d;
            3'd1: return o & d;
            3'd2: return o | d;
            3'd3: return o ^ d;
            3'd4: return ~o;
            default: return o;
        endcase
    endfunction

    function automatic logic [3:0] lane_cx(input logic hz, input logic [3:0] x, input int i);
        return hz ? x + 4'(DW - 1 - i) : x;
    endfunction

    function automatic logic [3:0] lane_cy(input logic hz, input logic [3:0] y, input int i);
        return hz ? y : y + 4'(DW - 1 - i);
    endfunction

    task automatic check_mem(input string req);
        int bad = 0;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                if (pix[y][x] !== refm[y][x]) bad++;
        chk(bad == 0, req, "store vs reference mismatches", 64'(bad), 64'd0);
    endtask

    task automatic load_mask(input logic [7:0] m);
        @(negedge clk);
        mask_we = 1'b1;
        mask_in = m;
        @(negedge clk);
        mask_we = 1'b0;
        cur_mask = m;
    endtask

    // mode 0 plain, 1 read requested too, 2 rival requests while busy, 3 mask load while busy
    task automatic do_write(input logic [2:0] op, input logic hz, input logic [3:0] x,
                            input logic [3:0] y, input logic [7:0] d, input int mode);
        logic [31:0] ex, ey;
        logic [7:0] exp_we;
        @(negedge clk);
        req_wr = 1'b1; req_rd = (mode == 1); req_op = op; req_horiz = hz;
        req_x = x; req_y = y; req_data = d;
        @(negedge clk);                       // after accepting edge
        req_wr = 1'b0; req_rd = 1'b0;
        if (mode == 2) begin
            req_wr = 1'b1; req_rd = 1'b1; req_op = 3'd0; req_data = ~d; req_x = x ^ 4'd8;
        end
        if (mode == 3) begin
            mask_we = 1'b1; mask_in = 8'hF0;
        end
        chk(busy && mem_rd, "R2", "fetch cycle busy/mem_rd", {busy, mem_rd}, 2'b11);
        for (int i = 0; i < DW; i++) begin
            ex[i*4 +: 4] = lane_cx(hz, x, i);
            ey[i*4 +: 4] = lane_cy(hz, y, i);
        end
        chk(mem_x == ex, "R3", "lane columns", mem_x, ex);
        chk(mem_y == ey, "R3", "lane rows", mem_y, ey);
        for (int i = 0; i < DW; i++)
            if (cur_mask[i] && op <= 3'd4)
                refm[ey[i*4 +: 4]][ex[i*4 +: 4]] = ref_bit(op, refm[ey[i*4 +: 4]][ex[i*4 +: 4]], d[i]);
        @(negedge clk);                       // write-back cycle
        req_wr = 1'b0; req_rd = 1'b0; mask_we = 1'b0;
        exp_we = (op <= 3'd4) ? cur_mask : 8'h00;
        chk(mem_we == exp_we, (op <= 3'd4) ? "R5" : "R6", "write enables", mem_we, exp_we);
        chk(busy && !mem_rd && !rd_valid, "R2", "commit cycle busy/mem_rd/rd_valid",
            {busy, mem_rd, rd_valid}, 3'b100);
        @(negedge clk);                       // after write-back edge
        chk(!busy && mem_we == '0, "R2", "idle after two cycles", {busy, mem_we}, 9'd0);
        check_mem((mode == 0) ? "R4" : (mode == 3) ? "R9" : "R8");
        if (mode == 3) cur_mask = 8'hF0;
    endtask

    task automatic do_read(input logic hz, input logic [3:0] x, input logic [3:0] y, input string req);
        logic [7:0] exp;
        @(negedge clk);
        req_rd = 1'b1; req_horiz = hz; req_x = x; req_y = y;
        @(negedge clk);
        req_rd = 1'b0;
        chk(busy && mem_rd && !rd_valid, "R7", "read fetch cycle", {busy, mem_rd, rd_valid}, 3'b110);
        @(negedge clk);
        for (int i = 0; i < DW; i++)
            exp[i] = refm[lane_cy(hz, y, i)][lane_cx(hz, x, i)] & cur_mask[i];
        chk(rd_valid && rd_data == exp, req, "masked read data", {rd_valid, rd_data}, {1'b1, exp});
        @(negedge clk);
        chk(!rd_valid && !busy, "R7", "rd_valid single cycle", {rd_valid, busy}, 2'b00);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [27:0] v;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                refm[y][x] = init_bit(x, y);
        repeat (4) @(negedge clk);
        chk(!busy && !rd_valid && !mem_rd && mem_we == '0, "R1", "outputs in reset",
            {busy, rd_valid, mem_rd, mem_we}, 11'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_valid && !mem_rd && mem_we == '0, "R1", "outputs after reset",
            {busy, rd_valid, mem_rd, mem_we}, 11'd0);
        check_mem("R1");
        do_read(1'b0, 4'd2, 4'd3, "R1");      // mask resets to all ones

        // Table of vectors: masked write, then masked read of the same byte.
        for (int n = 0; n < NV; n++) begin
            v = VEC[n];
            load_mask(v[7:0]);
            do_write(v[27:25], v[24], v[23:20], v[19:16], v[15:8], 0);
            do_read(v[24], v[23:20], v[19:16], "R7");
        end

        // R4: invert ignores host data, two different bytes give the same effect.
        load_mask(8'hFF);
        do_write(3'd4, 1'b0, 4'd5, 4'd1, 8'h00, 0);
        do_write(3'd4, 1'b0, 4'd5, 4'd1, 8'hFF, 0);
        do_read(1'b0, 4'd5, 4'd1, "R4");

        // R8: write and read requested together, only the write runs.
        do_write(3'd0, 1'b1, 4'd6, 4'd12, 8'hC3, 1);
        // R8: rival requests while busy are ignored.
        do_write(3'd3, 1'b0, 4'd1, 4'd4, 8'h77, 2);
        @(negedge clk);
        chk(!busy, "R8", "no transaction from ignored requests", busy, 1'b0);
        check_mem("R8");

        // R9: mask load during a transaction applies only to the next one.
        load_mask(8'h0F);
        do_write(3'd0, 1'b1, 4'd8, 4'd2, 8'hFF, 3);
        do_write(3'd0, 1'b1, 4'd8, 4'd2, 8'h00, 0);
        do_read(1'b1, 4'd8, 4'd2, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule